// File: doc/BRIEF.md
# Branch Decision and Target Unit

This unit resolves program-flow instructions for an 8-bit controller core. Each cycle the sequencer may present one branch operation together with the operands it needs. These are the fall-through program counter (already past the instruction), the accumulator, the carry flag, a selected bit, two compare operands, a loop counter, an 8-bit relative displacement, an absolute address and the data pointer. The unit decides whether the branch is taken and produces the next program counter. It also produces the side results that some branches carry: a new carry after a compare, a decremented loop counter to write back, and a request to clear the bit that was tested.

No zero flag exists in this core, so zero tests look at the accumulator value directly. Compare-and-branch and decrement-and-branch are each a single operation. A short absolute form replaces only the low 11 bits of the program counter and stays inside the current 2 KB page. Stack handling for calls and returns is done elsewhere. All results are registered and appear one cycle after the operation is accepted.

Top module: `branch_unit`

## Requirements
- R1: While rst_n is low, res_valid, taken, bit_clr, next_pc, new_carry and cnt_wb are all zero.
- R2: An operation presented with op_valid high at a rising edge produces its results with res_valid high after the next rising edge; with op_valid low, res_valid is low one cycle later.
- R3: Op code 0 (relative jump) is always taken, with target = fall-through PC + sign-extended displacement; displacement 7Fh reaches +127 and 80h reaches -128, modulo 2^16.
- R4: Op code 1 (page jump) is always taken; the target keeps PC bits 15..11 of the fall-through PC and takes bits 10..0 from the absolute address.
- R5: Op code 2 (long jump) is always taken to the full 16-bit absolute address; op code 3 (indexed jump) is always taken to accumulator + data pointer, modulo 2^16.
- R6: Op code 4 is taken when the accumulator is zero, op code 5 when it is nonzero; both target the relative address.
- R7: Op codes 6 and 7 are taken when the carry is 1 and 0 respectively; op codes 8 and 9 are taken when the selected bit is 1 and 0 respectively; all target the relative address.
- R8: Op code 10 is taken when the selected bit is 1, and then bit_clr is high; when the bit is 0 it is not taken and bit_clr is low. No other op code raises bit_clr.
- R9: Op code 11 compares cmp_a with cmp_b: it is taken (relative target) when they differ, and new_carry is 1 when cmp_a < cmp_b as unsigned values, else 0.
- R10: Op code 12 decrements the counter modulo 256 first, puts the result on cnt_wb, and is taken (relative target) when that result is nonzero; 1 gives 0 not taken, 0 gives FFh taken.
- R11: A branch that is not taken gives next_pc equal to the fall-through PC.
- R12: Every op code other than 11 passes carry_in to new_carry unchanged, and every op code other than 12 passes cnt_in to cnt_wb unchanged.
- R13: Op codes 13 to 15 are not branches: never taken, no bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Branch operation code |
| pc_fall | input | 16 | Fall-through program counter |
| acc | input | 8 | Accumulator value |
| carry_in | input | 1 | Current carry flag |
| bit_in | input | 1 | Value of the selected bit |
| cmp_a | input | 8 | First compare operand |
| cmp_b | input | 8 | Second compare operand |
| cnt_in | input | 8 | Loop counter before decrement |
| rel | input | 8 | Two's-complement displacement |
| abs_addr | input | 16 | Absolute address (low 11 bits for page jump) |
| dptr | input | 16 | Data pointer |
| res_valid | output | 1 | Results below belong to an accepted operation |
| taken | output | 1 | Branch is taken |
| next_pc | output | 16 | Next program counter |
| new_carry | output | 1 | Carry after the operation |
| cnt_wb | output | 8 | Counter value to write back |
| bit_clr | output | 1 | Request to clear the tested bit |

## Verification
Every result of this unit, the taken flag, target, carry, counter write-back and bit clear, is due exactly one clock after the edge at which the operation was accepted. The bench drives on the falling edge and queues the expected result. The monitor compares on the falling edge after the next rising edge, whenever res_valid is high, so each comparison lands one full cycle after its stimulus. Idle cycles are checked to show res_valid dropping in the same one-cycle step.

// File: rtl/bru_pkg.sv
package bru_pkg;

    typedef enum logic [3:0] {
        OP_REL   = 4'd0,
        OP_PAGE  = 4'd1,
        OP_LONG  = 4'd2,
        OP_INDEX = 4'd3,
        OP_ACCZ  = 4'd4,
        OP_ACCNZ = 4'd5,
        OP_CSET  = 4'd6,
        OP_CCLR  = 4'd7,
        OP_BSET  = 4'd8,
        OP_BCLR  = 4'd9,
        OP_BTAKE = 4'd10,
        OP_CMPNE = 4'd11,
        OP_DECNZ = 4'd12,
        OP_NONE  = 4'd13
    } br_op_e;

    function automatic logic is_branch(input logic [3:0] code);
        return code <= 4'd12;
    endfunction

endpackage

// File: rtl/bru_target.sv
module bru_target
    import bru_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int D_W    = 8,
    parameter int PAGE_W = 11
) (
    input  logic [3:0]      op,
    input  logic [PC_W-1:0] pc_fall,
    input  logic [D_W-1:0]  rel,
    input  logic [PC_W-1:0] abs_addr,
    input  logic [D_W-1:0]  acc,
    input  logic [PC_W-1:0] dptr,
    output logic [PC_W-1:0] target
);
    localparam int EXT_W = PC_W - D_W;

    logic [PC_W-1:0] rel_tgt;
    logic [PC_W-1:0] page_tgt;
    logic [PC_W-1:0] idx_tgt;

    always_comb begin
        rel_tgt  = pc_fall + {{EXT_W{rel[D_W-1]}}, rel};
        page_tgt = {pc_fall[PC_W-1:PAGE_W], abs_addr[PAGE_W-1:0]};
        idx_tgt  = dptr + {{EXT_W{1'b0}}, acc};
    end

    always_comb begin
        case (op)
            OP_PAGE:  target = page_tgt;
            OP_LONG:  target = abs_addr;
            OP_INDEX: target = idx_tgt;
            default:  target = rel_tgt;
        endcase
    end

endmodule

// File: rtl/bru_cond.sv
module bru_cond
    import bru_pkg::*;
#(
    parameter int D_W = 8
) (
    input  logic [3:0]     op,
    input  logic [D_W-1:0] acc,
    input  logic           carry_in,
    input  logic           bit_in,
    input  logic [D_W-1:0] cmp_a,
    input  logic [D_W-1:0] cmp_b,
    input  logic [D_W-1:0] cnt_in,
    output logic           take,
    output logic           carry_nx,
    output logic [D_W-1:0] cnt_nx,
    output logic           clr_req
);
    logic           acc_zero;
    logic           differ;
    logic           below;
    logic [D_W-1:0] cnt_dec;

    always_comb begin
        acc_zero = (acc == '0);
        differ   = (cmp_a != cmp_b);
        below    = (cmp_a < cmp_b);
        cnt_dec  = cnt_in - 1'b1;
    end

    always_comb begin
        take     = 1'b0;
        carry_nx = carry_in;
        cnt_nx   = cnt_in;
        clr_req  = 1'b0;
        case (op)
            OP_REL, OP_PAGE, OP_LONG, OP_INDEX: take = 1'b1;
            OP_ACCZ:  take = acc_zero;
            OP_ACCNZ: take = !acc_zero;
            OP_CSET:  take = carry_in;
            OP_CCLR:  take = !carry_in;
            OP_BSET:  take = bit_in;
            OP_BCLR:  take = !bit_in;
            OP_BTAKE: begin
                take    = bit_in;
                clr_req = bit_in;
            end
            OP_CMPNE: begin
                take     = differ;
                carry_nx = below;
            end
            OP_DECNZ: begin
                cnt_nx = cnt_dec;
                take   = (cnt_dec != '0);
            end
            default: take = 1'b0;
        endcase
    end

endmodule

// File: rtl/branch_unit.sv
module branch_unit
    import bru_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int D_W    = 8,
    parameter int PAGE_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [3:0]      op,
    input  logic [PC_W-1:0] pc_fall,
    input  logic [D_W-1:0]  acc,
    input  logic            carry_in,
    input  logic            bit_in,
    input  logic [D_W-1:0]  cmp_a,
    input  logic [D_W-1:0]  cmp_b,
    input  logic [D_W-1:0]  cnt_in,
    input  logic [D_W-1:0]  rel,
    input  logic [PC_W-1:0] abs_addr,
    input  logic [PC_W-1:0] dptr,
    output logic            res_valid,
    output logic            taken,
    output logic [PC_W-1:0] next_pc,
    output logic            new_carry,
    output logic [D_W-1:0]  cnt_wb,
    output logic            bit_clr
);
    typedef struct packed {
        logic            valid;
        logic            taken;
        logic [PC_W-1:0] pc;
        logic            carry;
        logic [D_W-1:0]  cnt;
        logic            clr;
    } res_t;

    res_t res_d, res_q;

    logic [PC_W-1:0] tgt;
    logic            c_take;
    logic            c_carry;
    logic [D_W-1:0]  c_cnt;
    logic            c_clr;

    bru_target #(.PC_W(PC_W), .D_W(D_W), .PAGE_W(PAGE_W)) u_target (
        .op       (op),
        .pc_fall  (pc_fall),
        .rel      (rel),
        .abs_addr (abs_addr),
        .acc      (acc),
        .dptr     (dptr),
        .target   (tgt)
    );

    bru_cond #(.D_W(D_W)) u_cond (
        .op       (op),
        .acc      (acc),
        .carry_in (carry_in),
        .bit_in   (bit_in),
        .cmp_a    (cmp_a),
        .cmp_b    (cmp_b),
        .cnt_in   (cnt_in),
        .take     (c_take),
        .carry_nx (c_carry),
        .cnt_nx   (c_cnt),
        .clr_req  (c_clr)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = op_valid;
        if (op_valid) begin
            res_d.taken = c_take && is_branch(op);
            res_d.pc    = res_d.taken ? tgt : pc_fall;
            res_d.carry = c_carry;
            res_d.cnt   = c_cnt;
            res_d.clr   = c_clr && res_d.taken;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid = res_q.valid;
    assign taken     = res_q.taken;
    assign next_pc   = res_q.pc;
    assign new_carry = res_q.carry;
    assign cnt_wb    = res_q.cnt;
    assign bit_clr   = res_q.clr;

endmodule

// File: rtl/bru_chk.sv
module bru_chk #(
    parameter int PC_W = 16,
    parameter int D_W  = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic [3:0]      op,
    input logic [PC_W-1:0] pc_fall,
    input logic            carry_in,
    input logic            bit_in,
    input logic [D_W-1:0]  cnt_in,
    input logic            res_valid,
    input logic            taken,
    input logic [PC_W-1:0] next_pc,
    input logic            new_carry,
    input logic [D_W-1:0]  cnt_wb,
    input logic            bit_clr
);
    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    // R11
    fallthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (taken || next_pc == $past(pc_fall)));

    // R8
    clr_only_btake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op != 4'd10) |=> !bit_clr);

    // R8
    clr_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == 4'd10) |=> (bit_clr == $past(bit_in) && taken == bit_clr));

    // R12
    carry_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op != 4'd11) |=> new_carry == $past(carry_in));

    // R10
    dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == 4'd12) |=> (cnt_wb == $past(cnt_in) - 1'b1 && taken == (cnt_wb != '0)));

    // R13
    nobranch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op >= 4'd13) |=> (!taken && !bit_clr));

endmodule

bind branch_unit bru_chk #(.PC_W(PC_W), .D_W(D_W)) u_bru_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op        (op),
    .pc_fall   (pc_fall),
    .carry_in  (carry_in),
    .bit_in    (bit_in),
    .cnt_in    (cnt_in),
    .res_valid (res_valid),
    .taken     (taken),
    .next_pc   (next_pc),
    .new_carry (new_carry),
    .cnt_wb    (cnt_wb),
    .bit_clr   (bit_clr)
);

// File: tb/tb_branch_unit.sv
module tb_branch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [15:0] pc_fall = '0;
    logic [7:0]  acc = '0;
    logic        carry_in = 1'b0;
    logic        bit_in = 1'b0;
    logic [7:0]  cmp_a = '0;
    logic [7:0]  cmp_b = '0;
    logic [7:0]  cnt_in = '0;
    logic [7:0]  rel = '0;
    logic [15:0] abs_addr = '0;
    logic [15:0] dptr = '0;
    logic        res_valid, taken, new_carry, bit_clr;
    logic [15:0] next_pc;
    logic [7:0]  cnt_wb;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic        tk;
        logic [15:0] pc;
        logic        c;
        logic [7:0]  cnt;
        logic        clr;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    branch_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op),
        .pc_fall(pc_fall), .acc(acc), .carry_in(carry_in), .bit_in(bit_in),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .cnt_in(cnt_in), .rel(rel),
        .abs_addr(abs_addr), .dptr(dptr), .res_valid(res_valid),
        .taken(taken), .next_pc(next_pc), .new_carry(new_carry),
        .cnt_wb(cnt_wb), .bit_clr(bit_clr)
    );

    function automatic exp_t model(input logic [3:0] o, input logic [15:0] pc,
                                   input logic [7:0] a, input logic c, input logic b,
                                   input logic [7:0] ca, input logic [7:0] cb,
                                   input logic [7:0] n, input logic [7:0] r,
                                   input logic [15:0] ab, input logic [15:0] dp,
                                   input string tag);
        exp_t e;
        logic [15:0] rt;
        logic [15:0] t;
        rt = pc + {{8{r[7]}}, r};
        t = rt;
        e.tk = 1'b0; e.c = c; e.cnt = n; e.clr = 1'b0; e.req = tag;
        case (o)
            4'd0: e.tk = 1'b1;
            4'd1: begin e.tk = 1'b1; t = {pc[15:11], ab[10:0]}; end
            4'd2: begin e.tk = 1'b1; t = ab; end
            4'd3: begin e.tk = 1'b1; t = dp + {8'h00, a}; end
            4'd4: e.tk = (a == 8'h00);
            4'd5: e.tk = (a != 8'h00);
            4'd6: e.tk = c;
            4'd7: e.tk = !c;
            4'd8: e.tk = b;
            4'd9: e.tk = !b;
            4'd10: begin e.tk = b; e.clr = b; end
            4'd11: begin e.tk = (ca != cb); e.c = (ca < cb); end
            4'd12: begin e.cnt = n - 8'd1; e.tk = (e.cnt != 8'h00); end
            default: e.tk = 1'b0;
        endcase
        e.pc = e.tk ? t : pc;
        return e;
    endfunction

    task automatic drive(input logic [3:0] o, input logic [15:0] pc,
                         input logic [7:0] a, input logic c, input logic b,
                         input logic [7:0] ca, input logic [7:0] cb,
                         input logic [7:0] n, input logic [7:0] r,
                         input logic [15:0] ab, input logic [15:0] dp,
                         input string tag);
        @(negedge clk);
        op = o; pc_fall = pc; acc = a; carry_in = c; bit_in = b;
        cmp_a = ca; cmp_b = cb; cnt_in = n; rel = r; abs_addr = ab; dptr = dp;
        op_valid = 1'b1;
        sb.push_back(model(o, pc, a, c, b, ca, cb, n, r, ab, dp, tag));
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            op_valid = 1'b0;
        end
    endtask

    // monitor: results are due one cycle after the accepting edge
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            exp_t e;
            total++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL R2: res_valid=1 with nothing expected");
            end else begin
                e = sb.pop_front();
                if (taken !== e.tk || next_pc !== e.pc || new_carry !== e.c ||
                    cnt_wb !== e.cnt || bit_clr !== e.clr) begin
                    bad++;
                    $display("FAIL %s: act tk=%b pc=%h c=%b cnt=%h clr=%b exp tk=%b pc=%h c=%b cnt=%h clr=%b",
                             e.req, taken, next_pc, new_carry, cnt_wb, bit_clr,
                             e.tk, e.pc, e.c, e.cnt, e.clr);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, act=running exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        total++;
        if (res_valid !== 1'b0 || taken !== 1'b0 || bit_clr !== 1'b0 ||
            next_pc !== 16'h0 || new_carry !== 1'b0 || cnt_wb !== 8'h0) begin
            bad++;
            $display("FAIL R1: act v=%b tk=%b pc=%h c=%b cnt=%h clr=%b exp all zero",
                     res_valid, taken, next_pc, new_carry, cnt_wb, bit_clr);
        end
        rst_n = 1'b1;

        // R3 relative reach
        drive(4'd0, 16'h1000, 8'h00, 0, 0, 0, 0, 8'h33, 8'h7F, 16'h0, 16'h0, "R3");
        drive(4'd0, 16'h1000, 8'h00, 1, 0, 0, 0, 8'h33, 8'h80, 16'h0, 16'h0, "R3");
        drive(4'd0, 16'h0010, 8'h00, 0, 0, 0, 0, 8'h00, 8'hF0, 16'h0, 16'h0, "R3");
        // R4 page jump
        drive(4'd1, 16'h2803, 8'h00, 0, 0, 0, 0, 8'h00, 8'h00, 16'hFA34, 16'h0, "R4");
        // R5 long and indexed
        drive(4'd2, 16'h0123, 8'h00, 0, 0, 0, 0, 8'h00, 8'h00, 16'hBEEF, 16'h0, "R5");
        drive(4'd3, 16'h0123, 8'hF0, 0, 0, 0, 0, 8'h00, 8'h00, 16'h0, 16'hFFF0, "R5");
        // R6 accumulator zero tests
        drive(4'd4, 16'h0400, 8'h00, 0, 0, 0, 0, 8'h00, 8'h05, 16'h0, 16'h0, "R6");
        drive(4'd4, 16'h0400, 8'h05, 0, 0, 0, 0, 8'h00, 8'h05, 16'h0, 16'h0, "R6 R11");
        drive(4'd5, 16'h0400, 8'h80, 0, 0, 0, 0, 8'h00, 8'hFE, 16'h0, 16'h0, "R6");
        drive(4'd5, 16'h0400, 8'h00, 0, 0, 0, 0, 8'h00, 8'hFE, 16'h0, 16'h0, "R6 R11");
        // R7 carry and bit tests
        drive(4'd6, 16'h0500, 8'h00, 1, 0, 0, 0, 8'h00, 8'h10, 16'h0, 16'h0, "R7");
        drive(4'd6, 16'h0500, 8'h00, 0, 0, 0, 0, 8'h00, 8'h10, 16'h0, 16'h0, "R7");
        drive(4'd7, 16'h0500, 8'h00, 0, 1, 0, 0, 8'h00, 8'h10, 16'h0, 16'h0, "R7");
        drive(4'd8, 16'h0500, 8'h00, 0, 1, 0, 0, 8'h00, 8'h10, 16'h0, 16'h0, "R7");
        drive(4'd9, 16'h0500, 8'h00, 1, 1, 0, 0, 8'h00, 8'h10, 16'h0, 16'h0, "R7 R12");
        // R8 test-and-clear
        drive(4'd10, 16'h0600, 8'h00, 0, 1, 0, 0, 8'h00, 8'h08, 16'h0, 16'h0, "R8");
        drive(4'd10, 16'h0600, 8'h00, 0, 0, 0, 0, 8'h00, 8'h08, 16'h0, 16'h0, "R8");
        // R9 compare and branch
        drive(4'd11, 16'h0700, 8'h00, 0, 0, 8'h10, 8'h20, 8'h00, 8'hFC, 16'h0, 16'h0, "R9");
        drive(4'd11, 16'h0700, 8'h00, 1, 0, 8'h20, 8'h10, 8'h00, 8'hFC, 16'h0, 16'h0, "R9");
        drive(4'd11, 16'h0700, 8'h00, 1, 0, 8'h44, 8'h44, 8'h00, 8'hFC, 16'h0, 16'h0, "R9");
        drive(4'd11, 16'h0700, 8'h00, 0, 0, 8'h7F, 8'h80, 8'h00, 8'h02, 16'h0, 16'h0, "R9");
        // R10 decrement and branch
        drive(4'd12, 16'h0800, 8'h00, 1, 0, 0, 0, 8'h01, 8'hFA, 16'h0, 16'h0, "R10");
        drive(4'd12, 16'h0800, 8'h00, 0, 0, 0, 0, 8'h00, 8'hFA, 16'h0, 16'h0, "R10");
        drive(4'd12, 16'h0800, 8'h00, 0, 0, 0, 0, 8'h05, 8'hFA, 16'h0, 16'h0, "R10");
        // R13 non-branch codes, R12 pass-through
        drive(4'd13, 16'h0900, 8'h00, 1, 1, 0, 0, 8'h5A, 8'h10, 16'hFFFF, 16'h0, "R13 R12");
        drive(4'd15, 16'h0900, 8'h00, 0, 1, 0, 0, 8'hA5, 8'h10, 16'hFFFF, 16'h0, "R13");
        idle(1);
        // R2: idle cycle gives res_valid low one cycle later
        @(negedge clk);
        total++;
        if (res_valid !== 1'b0) begin
            bad++;
            $display("FAIL R2: res_valid act=%b exp=0 after idle", res_valid);
        end
        // back-to-back after idle
        drive(4'd0, 16'hFFF0, 8'h00, 0, 0, 0, 0, 8'h00, 8'h7F, 16'h0, 16'h0, "R2 R3");
        idle(3);
        total++;
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL R2: pending results act=%0d exp=0", sb.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule